// File: doc/BRIEF.md
# Split-Phase Bidirectional Serial Reader

This block reads bytes from a serial flash device that shares one bidirectional data pin for both directions and needs an unusual read timing. Software opens a session with a start command, which lifts the serial clock pin high, and closes it with a stop command, which drops the clock low and releases the data pin. While a session is open, software sets the pin's output enable and the driven bit directly through a control write; the shifter never changes the pin direction.

A byte is fetched in two separately triggered phases. A first trigger produces one serial clock pulse and leaves the clock high. The clock then stays high for as long as software waits. A second trigger produces seven more pulses, and the eighth bit completes the received byte. Bits are sampled on each rising clock edge and assembled with the most significant bit first. A busy flag covers each burst. An error flag catches a second trigger that has no completed first phase in front of it.

Top module: `split_rd_if`

## Requirements
- R1: After reset the clock pin is low, the output enable is off, busy and error are low, and the received byte reads 0x00.
- R2: A start command outside a session opens a session and drives the clock high in the next cycle. While a session is open and no burst runs, the clock stays high for any length of time.
- R3: A first trigger in an idle session makes exactly one clock pulse. The pulse is low for HALF_CYC cycles and then high for HALF_CYC cycles, and the clock stays high afterwards.
- R4: A second trigger after a completed first phase makes exactly seven clock pulses. The data pin is sampled at every rising clock edge, the eight bits are packed MSB first, and the byte appears on rx_data_o with a one-cycle rx_valid_o pulse in the cycle after the seventh rising edge of that phase.
- R5: busy_o is high from the cycle after an accepted trigger until the last high half of the burst ends. Triggers that arrive while busy_o is high are ignored.
- R6: A second trigger in an idle session with no pending first phase sets err_o, makes no clock pulse and leaves busy_o low. err_o stays set until the next start command clears it.
- R7: In a session, a control write loads sd_oe_o from ctl_oe_i and sd_o from ctl_dat_i in the next cycle. Control writes outside a session are ignored.
- R8: A stop command takes priority over all other inputs. In the next cycle the clock is low, the output enable is off, busy_o is low, and any running burst or pending first phase is dropped.
- R9: Both triggers are ignored outside a session: no clock pulse, no busy and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start_i | input | 1 | One-cycle start command, opens a session |
| cmd_stop_i | input | 1 | One-cycle stop command, closes the session |
| ctl_wr_i | input | 1 | Control write strobe for the pin direction and value |
| ctl_oe_i | input | 1 | Output enable value for the data pin |
| ctl_dat_i | input | 1 | Value driven on the data pin while enabled |
| rd_first_i | input | 1 | First-phase trigger, one clock |
| rd_rest_i | input | 1 | Second-phase trigger, seven clocks |
| sd_i | input | 1 | Data pin input level |
| sd_o | output | 1 | Data pin output value |
| sd_oe_o | output | 1 | Data pin output enable |
| sclk_o | output | 1 | Serial clock pin |
| busy_o | output | 1 | High while a clock burst runs |
| err_o | output | 1 | Sticky flag for a second trigger without a first phase |
| rx_data_o | output | 8 | Last completed received byte |
| rx_valid_o | output | 1 | One-cycle pulse when rx_data_o is updated |

## Verification
The assertions assume that every command and trigger is a synchronous one-cycle pulse and that start and stop never arrive in the same cycle. They also assume that sd_i is stable at the system clock edge where the serial clock rises. The stimulus drives every input at the falling system edge. It changes the modelled pin level only after a serial rising edge, and it issues start and stop from separate steps. Random gaps, random bytes and random control writes stay within these limits.

// File: rtl/sprd_pkg.sv
package sprd_pkg;
    localparam int BYTE_W    = 8;
    localparam int REST_CLKS = BYTE_W - 1;
    localparam int LEFT_W    = $clog2(REST_CLKS + 1);

    typedef enum logic [1:0] {
        ST_OFF,
        ST_HOLD,
        ST_LOW,
        ST_HIGH
    } sprd_state_e;

    typedef struct packed {
        sprd_state_e        st;
        logic               sclk;
        logic               oe;
        logic               dat;
        logic               pending;
        logic               err;
        logic               rest_phase;
        logic [LEFT_W-1:0]  left;
    } sprd_seq_t;
endpackage

// File: rtl/sprd_half_timer.sv
module sprd_half_timer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d  = cur_q;
        tick_o = 1'b0;
        if (!run_i) begin
            nxt_d.cnt = '0;
        end else if (cur_q.cnt == LAST) begin
            tick_o    = 1'b1;
            nxt_d.cnt = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end
endmodule

// File: rtl/sprd_byte_asm.sv
module sprd_byte_asm #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         shift_i,
    input  logic         bit_i,
    input  logic         done_i,
    output logic [W-1:0] byte_o,
    output logic         valid_o
);
    typedef struct packed {
        logic [W-1:0] sh;
        logic [W-1:0] byte_v;
        logic         valid;
    } asm_t;

    asm_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = 1'b0;
        if (clear_i) begin
            nxt_d.sh = '0;
        end else if (shift_i) begin
            nxt_d.sh = {cur_q.sh[W-2:0], bit_i};
            if (done_i) begin
                nxt_d.byte_v = {cur_q.sh[W-2:0], bit_i};
                nxt_d.valid  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign byte_o  = cur_q.byte_v;
    assign valid_o = cur_q.valid;
endmodule

// File: rtl/split_rd_if.sv
module split_rd_if
    import sprd_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start_i,
    input  logic              cmd_stop_i,
    input  logic              ctl_wr_i,
    input  logic              ctl_oe_i,
    input  logic              ctl_dat_i,
    input  logic              rd_first_i,
    input  logic              rd_rest_i,
    input  logic              sd_i,
    output logic              sd_o,
    output logic              sd_oe_o,
    output logic              sclk_o,
    output logic              busy_o,
    output logic              err_o,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_valid_o
);
    localparam logic [LEFT_W-1:0] FIRST_CNT = LEFT_W'(1);
    localparam logic [LEFT_W-1:0] REST_CNT  = LEFT_W'(REST_CLKS);

    sprd_seq_t seq_q, seq_d;
    logic      tick;
    logic      shift_en;
    logic      done_en;
    logic      clear_en;
    logic      in_burst;
    logic      in_session;

    assign in_burst   = (seq_q.st == ST_LOW) || (seq_q.st == ST_HIGH);
    assign in_session = (seq_q.st != ST_OFF);

    sprd_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (in_burst),
        .tick_o (tick)
    );

    always_comb begin
        seq_d    = seq_q;
        shift_en = 1'b0;
        done_en  = 1'b0;
        clear_en = 1'b0;
        if (cmd_stop_i) begin
            seq_d.st         = ST_OFF;
            seq_d.sclk       = 1'b0;
            seq_d.oe         = 1'b0;
            seq_d.pending    = 1'b0;
            seq_d.rest_phase = 1'b0;
            seq_d.left       = '0;
        end else begin
            if (in_session && ctl_wr_i) begin
                seq_d.oe  = ctl_oe_i;
                seq_d.dat = ctl_dat_i;
            end
            case (seq_q.st)
                ST_OFF: begin
                    if (cmd_start_i) begin
                        seq_d.st   = ST_HOLD;
                        seq_d.sclk = 1'b1;
                        seq_d.err  = 1'b0;
                    end
                end
                ST_HOLD: begin
                    if (rd_first_i) begin
                        seq_d.st         = ST_LOW;
                        seq_d.sclk       = 1'b0;
                        seq_d.left       = FIRST_CNT;
                        seq_d.rest_phase = 1'b0;
                        seq_d.pending    = 1'b0;
                        clear_en         = 1'b1;
                    end else if (rd_rest_i) begin
                        if (seq_q.pending) begin
                            seq_d.st         = ST_LOW;
                            seq_d.sclk       = 1'b0;
                            seq_d.left       = REST_CNT;
                            seq_d.rest_phase = 1'b1;
                            seq_d.pending    = 1'b0;
                        end else begin
                            seq_d.err = 1'b1;
                        end
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        seq_d.st   = ST_HIGH;
                        seq_d.sclk = 1'b1;
                        seq_d.left = seq_q.left - 1'b1;
                        shift_en   = 1'b1;
                        done_en    = seq_q.rest_phase && (seq_q.left == FIRST_CNT);
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        if (seq_q.left == '0) begin
                            seq_d.st      = ST_HOLD;
                            seq_d.pending = !seq_q.rest_phase;
                        end else begin
                            seq_d.st   = ST_LOW;
                            seq_d.sclk = 1'b0;
                        end
                    end
                end
                default: seq_d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_OFF;
        end else begin
            seq_q <= seq_d;
        end
    end

    sprd_byte_asm #(.W(BYTE_W)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_en),
        .shift_i (shift_en),
        .bit_i   (sd_i),
        .done_i  (done_en),
        .byte_o  (rx_data_o),
        .valid_o (rx_valid_o)
    );

    assign sclk_o  = seq_q.sclk;
    assign sd_oe_o = seq_q.oe;
    assign sd_o    = seq_q.dat;
    assign busy_o  = in_burst;
    assign err_o   = seq_q.err;
endmodule

// File: rtl/split_rd_if_chk.sv
module split_rd_if_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_start_i,
    input logic cmd_stop_i,
    input logic rd_rest_i,
    input logic ctl_wr_i,
    input logic sclk_o,
    input logic sd_oe_o,
    input logic busy_o,
    input logic err_o,
    input logic rx_valid_o,
    input logic in_session,
    input logic pending
);
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop_i |=> (!sclk_o && !sd_oe_o && !busy_o)); // R8

    AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_session && !busy_o) |-> sclk_o); // R2

    AST_ORPHAN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rest_i && in_session && !busy_o && !pending && !cmd_stop_i) |=> (err_o && !busy_o)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !cmd_start_i) |=> err_o); // R6

    AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> (sclk_o && busy_o)); // R4

    AST_OE_NEEDS_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe_o |-> in_session); // R7

    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_session |-> (!sclk_o && !busy_o)); // R9
endmodule

bind split_rd_if split_rd_if_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start_i (cmd_start_i),
    .cmd_stop_i  (cmd_stop_i),
    .rd_rest_i   (rd_rest_i),
    .ctl_wr_i    (ctl_wr_i),
    .sclk_o      (sclk_o),
    .sd_oe_o     (sd_oe_o),
    .busy_o      (busy_o),
    .err_o       (err_o),
    .rx_valid_o  (rx_valid_o),
    .in_session  (in_session),
    .pending     (seq_q.pending)
);

// File: tb/sim_split_rd_if.sv
module sim_split_rd_if;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start_i = 1'b0, cmd_stop_i = 1'b0, ctl_wr_i = 1'b0;
    logic       ctl_oe_i = 1'b0, ctl_dat_i = 1'b0;
    logic       rd_first_i = 1'b0, rd_rest_i = 1'b0;
    logic       sd_i;
    logic       sd_o, sd_oe_o, sclk_o, busy_o, err_o, rx_valid_o;
    logic [7:0] rx_data_o;

    int         checks = 0;
    int         errors = 0;
    logic [7:0] mbyte = 8'h00;
    int         rises = 0;
    int         valid_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_rd_if #(.HALF_CYC(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start_i(cmd_start_i), .cmd_stop_i(cmd_stop_i),
        .ctl_wr_i(ctl_wr_i), .ctl_oe_i(ctl_oe_i), .ctl_dat_i(ctl_dat_i),
        .rd_first_i(rd_first_i), .rd_rest_i(rd_rest_i), .sd_i(sd_i),
        .sd_o(sd_o), .sd_oe_o(sd_oe_o), .sclk_o(sclk_o), .busy_o(busy_o),
        .err_o(err_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o)
    );

    // flash model: next bit appears after each rising serial edge
    assign sd_i = (rises < 8) ? mbyte[7 - rises] : 1'b0;
    always @(posedge sclk_o) rises = rises + 1;
    always @(posedge clk) if (rx_valid_o) valid_seen = valid_seen + 1;

    function automatic int exp_rises(input bit first, input bit rest);
        return (first ? 1 : 0) + (rest ? 7 : 0);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy_o; i++) @(negedge clk);
    endtask

    task automatic read_byte(input logic [7:0] b, input int gap);
        logic ok_hi;
        mbyte = b; rises = 0; valid_seen = 0;
        pulse(rd_first_i);
        chk("R5 busy after first trigger", busy_o, 1'b1);
        wait_idle();
        chk("R3 one pulse in first phase", rises, exp_rises(1, 0));
        ok_hi = 1'b1;
        for (int i = 0; i < gap; i++) begin
            if (!sclk_o || busy_o) ok_hi = 1'b0;
            @(negedge clk);
        end
        chk("R2 clock held high in gap", ok_hi, 1'b1);
        pulse(rd_rest_i);
        wait_idle();
        chk("R4 seven more pulses", rises, exp_rises(1, 1));
        chk("R4 byte MSB first", rx_data_o, b);
        chk("R4 single valid pulse", valid_seen, 1);
        chk("R3 clock high after burst", sclk_o, 1'b1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        int lowc;
        seed = 17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 sclk", sclk_o, 1'b0);
        chk("R1 oe", sd_oe_o, 1'b0);
        chk("R1 busy", busy_o, 1'b0);
        chk("R1 err", err_o, 1'b0);
        chk("R1 rx", rx_data_o, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 triggers and R7 control writes outside a session
        rises = 0;
        pulse(rd_first_i);
        pulse(rd_rest_i);
        ctl_oe_i = 1'b1; ctl_dat_i = 1'b1;
        pulse(ctl_wr_i);
        repeat (20) @(negedge clk);
        chk("R9 no clocks outside session", rises, 0);
        chk("R9 no busy outside session", busy_o, 1'b0);
        chk("R9 no err outside session", err_o, 1'b0);
        chk("R7 write ignored outside session", sd_oe_o, 1'b0);

        // R2 start
        pulse(cmd_start_i);
        chk("R2 clock high after start", sclk_o, 1'b1);

        // R7 control write in session
        pulse(ctl_wr_i);
        chk("R7 oe loaded", sd_oe_o, 1'b1);
        chk("R7 data loaded", sd_o, 1'b1);
        ctl_oe_i = 1'b0; ctl_dat_i = 1'b0;
        pulse(ctl_wr_i);
        chk("R7 oe cleared", sd_oe_o, 1'b0);

        // R6 orphan second trigger
        rises = 0;
        pulse(rd_rest_i);
        chk("R6 err set", err_o, 1'b1);
        chk("R6 no busy", busy_o, 1'b0);
        repeat (10) @(negedge clk);
        chk("R6 no clock", rises, 0);
        chk("R6 err sticky", err_o, 1'b1);

        // R3 pulse shape: low for HALF cycles
        mbyte = 8'hA5; rises = 0;
        pulse(rd_first_i);
        lowc = 0;
        while (!sclk_o && lowc < 100) begin lowc++; @(negedge clk); end
        chk("R3 low half width", lowc, HALF);
        // R5 trigger during busy ignored
        pulse(rd_first_i);
        wait_idle();
        chk("R5 trigger while busy ignored", rises, 1);
        pulse(rd_rest_i);
        wait_idle();
        chk("R4 directed byte", rx_data_o, 8'hA5);

        // directed corner bytes
        read_byte(8'h00, 0);
        read_byte(8'hFF, 1);
        read_byte(8'h80, 5);
        read_byte(8'h01, 60);

        // random bytes and gaps
        for (int n = 0; n < 20; n++) begin
            read_byte(8'($urandom), int'($urandom % 50));
            if (($urandom % 3) == 0) begin
                ctl_oe_i = 1'($urandom); ctl_dat_i = 1'($urandom);
                pulse(ctl_wr_i);
                chk("R7 random write", {sd_oe_o, sd_o}, {ctl_oe_i, ctl_dat_i});
            end
        end

        // R8 stop mid-burst
        ctl_oe_i = 1'b1;
        pulse(ctl_wr_i);
        mbyte = 8'h3C; rises = 0;
        pulse(rd_first_i);
        wait_idle();
        pulse(rd_rest_i);
        repeat (12) @(negedge clk);
        pulse(cmd_stop_i);
        chk("R8 clock low", sclk_o, 1'b0);
        chk("R8 oe off", sd_oe_o, 1'b0);
        chk("R8 busy off", busy_o, 1'b0);
        repeat (20) @(negedge clk);
        chk("R8 burst aborted", sclk_o, 1'b0);

        // R6 cleared by start; pending dropped by stop
        chk("R6 err before start", err_o, 1'b1);
        pulse(cmd_start_i);
        chk("R6 err cleared by start", err_o, 1'b0);
        rises = 0;
        pulse(rd_rest_i);
        chk("R8 pending dropped", err_o, 1'b1);
        repeat (10) @(negedge clk);
        chk("R8 no clocks after drop", rises, 0);

        // R8 stop after a first phase drops pending
        pulse(cmd_stop_i);
        pulse(cmd_start_i);
        rises = 0;
        pulse(rd_first_i);
        wait_idle();
        pulse(cmd_stop_i);
        pulse(cmd_start_i);
        pulse(rd_rest_i);
        chk("R8 pending cleared by stop", err_o, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule